// File: doc/BRIEF.md
# Write-Count Wear-Leveling Set Controller

This block handles accesses for one set of a set-associative write-back cache whose storage cells survive only a limited number of writes. For every way it keeps a small write counter covering the way's current residency and an LRU age. A write hit normally updates the data array and bumps the hit way's counter. When the bumped value would reach a programmable threshold, the write is redirected out of the cache as a memory write-back and the way is invalidated, with its LRU position left alone. The next miss then replaces the true LRU way, so a frequently written line moves to a less worn way.

A flush also lowers the counters of the set's other resident lines by a programmable decay step, saturating at zero. Flushing therefore tracks how many writes a line has had compared with its neighbours, not just the raw total. The tag lookup sits upstream and supplies hit/miss, way and access type. Data storage and the memory port are outside the block. The block drives the array write enables, the fill way for misses, the per-way valid and dirty bits, and a write-back request that uses a valid/ready handshake.

Top module: `wl_set_ctrl`

## Requirements
- R1: After reset every way is invalid and clean, `arr_we`, `fill_we` and `wb_valid` are low, `acc_ready` is high, way i holds LRU age i (0 = most recent), so `victim_way` is WAYS-1.
- R2: A write hit (`acc_hit`=1, `acc_write`=1) whose incremented counter stays below `cfg_thresh` pulses `arr_we` for one cycle with `arr_we_way` = the hit way, sets that way's dirty bit and makes it most recently used.
- R3: A write hit whose incremented counter equals `cfg_thresh` gives no `arr_we`. It raises `wb_valid` with `wb_way` = the hit way, clears that way's valid and dirty bits and leaves every LRU age unchanged.
- R4: On such a flush, every other valid way has its counter lowered by `cfg_decay`, clamped at 0. Counters of invalid ways do not change. This is observed through the number of later writes each line needs before it flushes.
- R5: On a miss (`acc_hit`=0), the fill goes to the way holding the oldest age, even if another way is invalid. `fill_we` pulses with `fill_way` set to that way, and the way becomes valid and most recently used. A read miss leaves the line clean with counter 0. A write miss marks it dirty with counter 1.
- R6: A read hit only makes the way most recently used. It changes no counter and no valid or dirty bit, and it causes no array write.
- R7: `wb_valid` and `wb_way` hold until `wb_ready` is sampled high. `acc_ready` stays low while a write-back is pending, so no access is taken then.
- R8: Ages stay a permutation of 0..WAYS-1. An access that is not a flush moves its way to age 0 and ages by one every way that was younger than it. `victim_way` always names the single oldest way.
- R9: Use WAYS=4, threshold 3 and decay 0. Fill lines A..D so that A is youngest. Then run W B, W B, R E, W E, R F, W B, W B, R F, W B, W B. The result is 7 hits, 3 misses, 7 array writes (fills plus data writes) and 2 flushes, and only the ways holding F and E stay valid.
- R10: Counters are CNT_W bits wide. Any threshold from 2 to 2^CNT_W works, and at the maximum threshold of 16 the 16th write to a line flushes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request present |
| acc_ready | output | 1 | Access can be taken this cycle |
| acc_hit | input | 1 | Lookup hit (1) or miss (0) |
| acc_way | input | WAY_W | Hit way; ignored on a miss |
| acc_write | input | 1 | 1 = write, 0 = read |
| cfg_thresh | input | CNT_W+1 | Flush threshold, 2..2^CNT_W |
| cfg_decay | input | CNT_W | Decay step applied to other ways on a flush |
| arr_we | output | 1 | Data-array write for a write hit |
| arr_we_way | output | WAY_W | Way written by `arr_we` |
| fill_we | output | 1 | Line fill on a miss |
| fill_way | output | WAY_W | Way receiving the fill |
| victim_way | output | WAY_W | Current oldest way, the miss replacement target |
| wb_valid | output | 1 | Flush write-back request |
| wb_way | output | WAY_W | Way whose write was diverted |
| wb_ready | input | 1 | Memory side accepts the write-back |
| line_valid | output | WAYS | Per-way valid bits |
| line_dirty | output | WAYS | Per-way dirty bits |

## Verification
An access is taken on one rising edge. Every registered result of it (`arr_we`, `fill_we`, `wb_valid`, their way fields, and the valid and dirty bits) appears after that edge, so the bench samples them at the following falling edge. `victim_way` depends only on the current ages, so it is compared against the model's oldest way before each access is driven. While a write-back is pending, the bench keeps `wb_ready` low for a random number of cycles, checks `wb_valid`, `wb_way` and `acc_ready` at every falling edge, and checks that the request has dropped one cycle after `wb_ready` is taken. Counter decay and saturation have no port of their own. They are checked by counting how many writes a line needs before the falling edge that first shows `wb_valid`.

// File: rtl/wl_pkg.sv
package wl_pkg;

  // Classification of an accepted access.
  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_READ  = 3'd1,
    EV_WRITE = 3'd2,
    EV_FLUSH = 3'd3,
    EV_FILL  = 3'd4
  } wl_event_e;

endpackage

// File: rtl/wl_lru_ages.sv
module wl_lru_ages #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        touch_en,
  input  logic [WAY_W-1:0]            touch_way,
  output logic [WAYS-1:0][WAY_W-1:0]  age_q,
  output logic [WAY_W-1:0]            victim_way
);

  logic [WAYS-1:0][WAY_W-1:0] age_d;
  logic [WAY_W-1:0]           touched_age;

  assign touched_age = age_q[touch_way];

  for (genvar i = 0; i < WAYS; i++) begin : g_age
    always_comb begin
      age_d[i] = age_q[i];
      if (touch_way == WAY_W'(i)) begin
        age_d[i] = '0;
      end else if (age_q[i] < touched_age) begin
        age_d[i] = age_q[i] + WAY_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        age_q[i] <= WAY_W'(i);
      end else if (touch_en) begin
        age_q[i] <= age_d[i];
      end
    end
  end

  always_comb begin
    victim_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (age_q[i] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(i);
    end
  end

endmodule

// File: rtl/wl_wear_counters.sv
module wl_wear_counters #(
  parameter int WAYS  = 4,
  parameter int CNT_W = 4,
  parameter int WAY_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inc_en,
  input  logic                        flush_en,
  input  logic [WAY_W-1:0]            sel_way,
  input  logic                        fill_en,
  input  logic                        fill_write,
  input  logic [WAY_W-1:0]            fill_way,
  input  logic [CNT_W-1:0]            decay,
  input  logic [WAYS-1:0]             valid,
  output logic [WAYS-1:0][CNT_W-1:0]  cnt_q
);

  logic [WAYS-1:0][CNT_W-1:0] cnt_d;
  logic [WAYS-1:0]            cnt_en;

  for (genvar i = 0; i < WAYS; i++) begin : g_cnt
    always_comb begin
      cnt_d[i]  = cnt_q[i];
      cnt_en[i] = 1'b0;
      if (fill_en && fill_way == WAY_W'(i)) begin
        cnt_d[i]  = fill_write ? CNT_W'(1) : '0;
        cnt_en[i] = 1'b1;
      end else if (inc_en && sel_way == WAY_W'(i)) begin
        cnt_d[i]  = cnt_q[i] + CNT_W'(1);
        cnt_en[i] = 1'b1;
      end else if (flush_en && sel_way == WAY_W'(i)) begin
        cnt_d[i]  = '0;
        cnt_en[i] = 1'b1;
      end else if (flush_en && valid[i]) begin
        cnt_d[i]  = (cnt_q[i] > decay) ? (cnt_q[i] - decay) : '0;
        cnt_en[i] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[i] <= '0;
      end else if (cnt_en[i]) begin
        cnt_q[i] <= cnt_d[i];
      end
    end
  end

endmodule

// File: rtl/wl_set_ctrl.sv
module wl_set_ctrl
  import wl_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int CNT_W = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic             acc_hit,
  input  logic [WAY_W-1:0] acc_way,
  input  logic             acc_write,
  input  logic [CNT_W:0]   cfg_thresh,
  input  logic [CNT_W-1:0] cfg_decay,
  output logic             arr_we,
  output logic [WAY_W-1:0] arr_we_way,
  output logic             fill_we,
  output logic [WAY_W-1:0] fill_way,
  output logic [WAY_W-1:0] victim_way,
  output logic             wb_valid,
  output logic [WAY_W-1:0] wb_way,
  input  logic             wb_ready,
  output logic [WAYS-1:0]  line_valid,
  output logic [WAYS-1:0]  line_dirty
);

  logic                        acc_fire;
  wl_event_e                   evt;
  logic [CNT_W:0]              cnt_next;
  logic [WAYS-1:0][CNT_W-1:0]  cnt_q;
  logic [WAYS-1:0][WAY_W-1:0]  age_q;
  logic [WAY_W-1:0]            victim;
  logic                        touch_en;
  logic [WAY_W-1:0]            touch_way;

  logic [WAYS-1:0]  valid_q, valid_d, dirty_q, dirty_d;
  logic             arr_we_q, arr_we_d, fill_we_q, fill_we_d;
  logic             wb_valid_q, wb_valid_d;
  logic [WAY_W-1:0] arr_way_q, fill_way_q, wb_way_q;

  assign acc_ready = ~wb_valid_q;
  assign acc_fire  = acc_valid & acc_ready;

  // Classify the accepted access.
  always_comb begin
    cnt_next = {1'b0, cnt_q[acc_way]} + (CNT_W+1)'(1);
    evt      = EV_NONE;
    if (acc_fire) begin
      if (!acc_hit)                     evt = EV_FILL;
      else if (!acc_write)              evt = EV_READ;
      else if (cnt_next == cfg_thresh)  evt = EV_FLUSH;
      else                              evt = EV_WRITE;
    end
  end

  assign touch_en  = (evt == EV_READ) || (evt == EV_WRITE) || (evt == EV_FILL);
  assign touch_way = (evt == EV_FILL) ? victim : acc_way;

  wl_lru_ages #(.WAYS(WAYS), .WAY_W(WAY_W)) u_ages (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (touch_en),
    .touch_way  (touch_way),
    .age_q      (age_q),
    .victim_way (victim)
  );

  wl_wear_counters #(.WAYS(WAYS), .CNT_W(CNT_W), .WAY_W(WAY_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_en     (evt == EV_WRITE),
    .flush_en   (evt == EV_FLUSH),
    .sel_way    (acc_way),
    .fill_en    (evt == EV_FILL),
    .fill_write (acc_write),
    .fill_way   (victim),
    .decay      (cfg_decay),
    .valid      (valid_q),
    .cnt_q      (cnt_q)
  );

  // Next state of line flags and output strobes.
  always_comb begin
    valid_d    = valid_q;
    dirty_d    = dirty_q;
    arr_we_d   = (evt == EV_WRITE);
    fill_we_d  = (evt == EV_FILL);
    wb_valid_d = wb_valid_q & ~wb_ready;
    unique case (evt)
      EV_FILL: begin
        valid_d[victim] = 1'b1;
        dirty_d[victim] = acc_write;
      end
      EV_WRITE: dirty_d[acc_way] = 1'b1;
      EV_FLUSH: begin
        valid_d[acc_way] = 1'b0;
        dirty_d[acc_way] = 1'b0;
        wb_valid_d       = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= '0;
      dirty_q    <= '0;
      arr_we_q   <= 1'b0;
      fill_we_q  <= 1'b0;
      wb_valid_q <= 1'b0;
    end else begin
      valid_q    <= valid_d;
      dirty_q    <= dirty_d;
      arr_we_q   <= arr_we_d;
      fill_we_q  <= fill_we_d;
      wb_valid_q <= wb_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_way_q  <= '0;
      fill_way_q <= '0;
      wb_way_q   <= '0;
    end else begin
      if (evt == EV_WRITE) arr_way_q  <= acc_way;
      if (evt == EV_FILL)  fill_way_q <= victim;
      if (evt == EV_FLUSH) wb_way_q   <= acc_way;
    end
  end

  assign arr_we     = arr_we_q;
  assign arr_we_way = arr_way_q;
  assign fill_we    = fill_we_q;
  assign fill_way   = fill_way_q;
  assign wb_valid   = wb_valid_q;
  assign wb_way     = wb_way_q;
  assign victim_way = victim;
  assign line_valid = valid_q;
  assign line_dirty = dirty_q;

endmodule

// File: rtl/wl_set_ctrl_chk.sv
module wl_set_ctrl_chk #(
  parameter int WAYS  = 4,
  parameter int CNT_W = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        arr_we,
  input logic [WAY_W-1:0]            arr_we_way,
  input logic                        fill_we,
  input logic [WAY_W-1:0]            fill_way,
  input logic                        wb_valid,
  input logic [WAY_W-1:0]            wb_way,
  input logic                        wb_ready,
  input logic [WAYS-1:0]             line_valid,
  input logic [WAYS-1:0]             line_dirty,
  input logic [CNT_W:0]              cfg_thresh,
  input logic [WAYS-1:0][CNT_W-1:0]  cnt_q,
  input logic [WAYS-1:0][WAY_W-1:0]  age_q
);

  logic [WAYS-1:0] oldest_vec;
  always_comb begin
    for (int i = 0; i < WAYS; i++) oldest_vec[i] = (age_q[i] == WAY_W'(WAYS - 1));
  end

  assert_wb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_way)));

  assert_flushed_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (!line_valid[wb_way] && !line_dirty[wb_way]));

  assert_no_array_write_on_flush_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we || fill_we) |-> !wb_valid);

  assert_fill_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> line_valid[fill_way]);

  assert_write_dirty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (line_valid[arr_we_way] && line_dirty[arr_we_way]));

  assert_single_oldest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);

  for (genvar i = 0; i < WAYS; i++) begin : g_way
    assert_cnt_below_thresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
      line_valid[i] |-> ({1'b0, cnt_q[i]} < cfg_thresh));

    assert_invalid_cnt_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_valid[i] && $past(!line_valid[i])) |-> $stable(cnt_q[i]));
  end

endmodule

bind wl_set_ctrl wl_set_ctrl_chk #(.WAYS(WAYS), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .arr_we     (arr_we),
  .arr_we_way (arr_we_way),
  .fill_we    (fill_we),
  .fill_way   (fill_way),
  .wb_valid   (wb_valid),
  .wb_way     (wb_way),
  .wb_ready   (wb_ready),
  .line_valid (line_valid),
  .line_dirty (line_dirty),
  .cfg_thresh (cfg_thresh),
  .cnt_q      (cnt_q),
  .age_q      (age_q)
);

// File: tb/wl_set_ctrl_tb.sv
module wl_set_ctrl_tb;

  localparam int WAYS  = 4;
  localparam int CNT_W = 4;
  localparam int WAY_W = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             acc_valid, acc_ready, acc_hit, acc_write;
  logic [WAY_W-1:0] acc_way;
  logic [CNT_W:0]   cfg_thresh;
  logic [CNT_W-1:0] cfg_decay;
  logic             arr_we, fill_we, wb_valid, wb_ready;
  logic [WAY_W-1:0] arr_we_way, fill_way, victim_way, wb_way;
  logic [WAYS-1:0]  line_valid, line_dirty;

  always #10 clk = ~clk;

  wl_set_ctrl #(.WAYS(WAYS), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_hit(acc_hit), .acc_way(acc_way), .acc_write(acc_write),
    .cfg_thresh(cfg_thresh), .cfg_decay(cfg_decay), .arr_we(arr_we),
    .arr_we_way(arr_we_way), .fill_we(fill_we), .fill_way(fill_way),
    .victim_way(victim_way), .wb_valid(wb_valid), .wb_way(wb_way),
    .wb_ready(wb_ready), .line_valid(line_valid), .line_dirty(line_dirty)
  );

  int n_tests = 0, n_fail = 0;
  int n_arr = 0, n_fill = 0, n_wb = 0;
  int m_tag[WAYS], m_cnt[WAYS], m_age[WAYS];
  bit m_val[WAYS], m_dirty[WAYS];
  int thr, dec;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int m_victim();
    int v = 0;
    for (int i = 0; i < WAYS; i++) if (m_age[i] == WAYS - 1) v = i;
    return v;
  endfunction

  function automatic int m_lookup(int tag);
    int w = -1;
    for (int i = 0; i < WAYS; i++) if (m_val[i] && m_tag[i] == tag) w = i;
    return w;
  endfunction

  function automatic void m_touch(int w);
    int a;
    a = m_age[w];
    for (int i = 0; i < WAYS; i++) begin
      if (i == w) m_age[i] = 0;
      else if (m_age[i] < a) m_age[i]++;
    end
  endfunction

  function automatic int pack_val();
    int v = 0;
    for (int i = 0; i < WAYS; i++) if (m_val[i]) v |= (1 << i);
    return v;
  endfunction

  function automatic int pack_dirty();
    int v = 0;
    for (int i = 0; i < WAYS; i++) if (m_dirty[i]) v |= (1 << i);
    return v;
  endfunction

  task automatic do_reset(input int t, input int d);
    thr = t; dec = d;
    cfg_thresh = (CNT_W+1)'(t);
    cfg_decay  = CNT_W'(d);
    acc_valid = 0; acc_hit = 0; acc_way = '0; acc_write = 0; wb_ready = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < WAYS; i++) begin
      m_tag[i] = -1; m_cnt[i] = 0; m_age[i] = i; m_val[i] = 0; m_dirty[i] = 0;
    end
    @(negedge clk);
    // R1: reset state
    chk(line_valid == '0 && line_dirty == '0, "R1 valid/dirty after reset",
        int'({line_valid, line_dirty}), 0);
    chk(!arr_we && !fill_we && !wb_valid && acc_ready, "R1 strobes/ready after reset",
        int'({arr_we, fill_we, wb_valid, acc_ready}), 1);
    chk(victim_way == WAY_W'(WAYS - 1), "R1 victim after reset", int'(victim_way), WAYS - 1);
  endtask

  // One access; returns 1 if it flushed.
  task automatic access(input int tag, input bit wr, output bit flushed);
    int way, vict, hold;
    bit e_arr, e_fill;
    way = m_lookup(tag);
    vict = m_victim();
    e_arr = 0; e_fill = 0; flushed = 0;
    chk(acc_ready == 1'b1, "R7 ready before access", int'(acc_ready), 1);
    chk(victim_way == WAY_W'(vict), "R8 victim way (oldest age)", int'(victim_way), vict);
    acc_valid = 1; acc_hit = (way >= 0); acc_way = (way >= 0) ? WAY_W'(way) : '0;
    acc_write = wr;
    if (way < 0) begin
      e_fill = 1;
      m_tag[vict] = tag; m_val[vict] = 1; m_dirty[vict] = wr; m_cnt[vict] = wr ? 1 : 0;
      m_touch(vict);
    end else if (wr) begin
      if (m_cnt[way] + 1 == thr) begin
        flushed = 1;
        m_val[way] = 0; m_dirty[way] = 0; m_cnt[way] = 0;
        for (int i = 0; i < WAYS; i++)
          if (i != way && m_val[i]) m_cnt[i] = (m_cnt[i] > dec) ? m_cnt[i] - dec : 0;
      end else begin
        e_arr = 1; m_cnt[way]++; m_dirty[way] = 1; m_touch(way);
      end
    end else begin
      m_touch(way);
    end
    @(negedge clk);
    acc_valid = 0;
    if (arr_we) n_arr++;
    if (fill_we) n_fill++;
    if (wb_valid) n_wb++;
    chk(arr_we == e_arr, "R2 arr_we", int'(arr_we), int'(e_arr));
    if (e_arr) chk(arr_we_way == WAY_W'(way), "R2 arr_we_way", int'(arr_we_way), way);
    chk(fill_we == e_fill, "R5 fill_we", int'(fill_we), int'(e_fill));
    if (e_fill) chk(fill_way == WAY_W'(vict), "R5 fill_way", int'(fill_way), vict);
    chk(wb_valid == flushed, "R3 wb_valid", int'(wb_valid), int'(flushed));
    if (flushed) chk(wb_way == WAY_W'(way), "R3 wb_way", int'(wb_way), way);
    chk(int'(line_valid) == pack_val(), "R3/R5 line_valid", int'(line_valid), pack_val());
    chk(int'(line_dirty) == pack_dirty(), "R2/R6 line_dirty", int'(line_dirty), pack_dirty());
    if (flushed) begin
      hold = $urandom_range(0, 3);
      for (int c = 0; c < hold; c++) begin
        @(negedge clk);
        chk(wb_valid && wb_way == WAY_W'(way) && !acc_ready, "R7 write-back held",
            int'({wb_valid, acc_ready}), 2);
      end
      wb_ready = 1;
      @(negedge clk);
      wb_ready = 0;
      chk(!wb_valid && acc_ready, "R7 write-back released", int'({wb_valid, acc_ready}), 1);
    end
  endtask

  int flush_at;
  bit f;

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));

    // R9: worked example, threshold 3, no decay. A=0 B=1 C=2 D=3 E=4 F=5
    do_reset(3, 0);
    access(3, 0, f); access(2, 0, f); access(1, 0, f); access(0, 0, f);
    n_arr = 0; n_fill = 0; n_wb = 0;
    access(1, 1, f); access(1, 1, f); access(4, 0, f); access(4, 1, f);
    access(5, 0, f); access(1, 1, f); access(1, 1, f); access(5, 0, f);
    access(1, 1, f); access(1, 1, f);
    chk(n_fill == 3, "R9 misses", n_fill, 3);
    chk(10 - n_fill == 7, "R9 hits", 10 - n_fill, 7);
    chk(n_arr + n_fill == 7, "R9 array writes", n_arr + n_fill, 7);
    chk(n_wb == 2, "R9 flushes", n_wb, 2);
    chk(line_valid == 4'b1100, "R9 final valid", int'(line_valid), 12);

    // R10: maximum threshold, 16th write flushes
    do_reset(16, 1);
    access(7, 0, f);
    flush_at = 0;
    for (int k = 1; k <= 16; k++) begin
      access(7, 1, f);
      if (f && flush_at == 0) flush_at = k;
    end
    chk(flush_at == 16, "R10 flush on write 16", flush_at, 16);

    // R4: decay saturates at zero (threshold 4, decay 2)
    do_reset(4, 2);
    access(0, 0, f); access(1, 0, f);
    access(0, 1, f);
    for (int k = 0; k < 4; k++) access(1, 1, f);
    flush_at = 0;
    for (int k = 1; k <= 4; k++) begin
      access(0, 1, f);
      if (f && flush_at == 0) flush_at = k;
    end
    chk(flush_at == 4, "R4 saturated decay, writes to flush", flush_at, 4);

    // R6: read hits leave the counter alone (threshold 3)
    do_reset(3, 0);
    access(2, 0, f); access(2, 1, f);
    for (int k = 0; k < 5; k++) access(2, 0, f);
    access(2, 1, f);
    chk(!f, "R6 no flush after reads", int'(f), 0);
    access(2, 1, f);
    chk(f, "R6 flush on third write", int'(f), 1);

    // Constrained random phases (R2..R8)
    for (int p = 0; p < 6; p++) begin
      do_reset($urandom_range(2, 6), $urandom_range(0, 2));
      for (int k = 0; k < 300; k++)
        access($urandom_range(0, 7), ($urandom_range(0, 9) < 6), f);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule